// File: doc/BRIEF.md
# Ethernet Pause Frame Flow Controller

This block decides, for every port of a bank of ingress FIFOs, when the MAC should send pause frames. Each port compares its FIFO fill level with a programmable high and low threshold. Crossing above the high mark puts the port into a pause state. The port leaves that state only when the level has drained down to the low mark, so the two thresholds form a hysteresis band. While paused, the port asks for a pause frame at once and then again each time a regeneration interval expires. The interval is given in pause quanta of `QUANTUM_BITS` bit times, and a bit-time tick input advances it.

Requests leave the block through a single valid/ready channel that carries the index of the requesting port. The block also keeps two sticky status vectors, near-full and full, that are cleared by read strobes. It drives one interrupt line that is gated by per-port mask bits. Register storage for thresholds, masks, enables and the regeneration time sits outside the block and is applied on input pins. On the register side the masks and enables reset to all ones and the regeneration time resets to 0xFFFF. Building the frames, transmitting them and the FIFOs themselves belong to other blocks.

Top module: `pause_flow_ctrl`

## Requirements
- R1: A port enters the pause state on the clock edge at which its fill level is strictly greater than its high threshold. A level equal to the high threshold neither enters the pause state nor marks the port near-full.
- R2: A paused port stays paused while its level is above its low threshold and leaves on the edge at which the level is at or below the low threshold. Leaving cancels the regeneration countdown and drops any request of that port that has not yet been placed on the output.
- R3: The first request of a pause episode is presented on `pause_valid` two edges after the level crosses the high threshold. Further requests follow every max(regen_time,1) × QUANTUM_BITS bit ticks, counted from the entry edge.
- R4: `pause_valid` stays high with `pause_port` unchanged until `pause_ready` is sampled high. `pause_port` is the binary index of the port. With `ROUND_ROBIN`=0, the lowest pending port index is served first.
- R5: Bit i of `nfull_stat` is set on a rising edge of (level i > high i), and bit i of `full_stat` on a rising edge of `fifo_full[i]`. Both bits stay set after the condition goes away.
- R6: A one-cycle `full_stat_rd` or `nfull_stat_rd` clears the whole matching status vector, except for any bit that is being set in the same cycle. Such a bit remains 1.
- R7: `irq` is the OR over all ports of (`full_stat` & ~`full_mask`) | (`nfull_stat` & ~`nfull_mask`). A mask bit of 1 suppresses the interrupt for that port.
- R8: A port whose `port_en` bit is 0 leaves the pause state, issues no requests and sets no status bits.
- R9: After reset, `pause_valid`, both status vectors and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | NPORT | Per-port enable |
| fill_lvl | input | NPORT*LVL_W | Packed per-port FIFO fill levels, port 0 in the low bits |
| fifo_full | input | NPORT | Per-port FIFO full flags |
| hi_thr | input | NPORT*LVL_W | Packed per-port high thresholds |
| lo_thr | input | NPORT*LVL_W | Packed per-port low thresholds |
| regen_time | input | TMR_W | Regeneration interval in pause quanta |
| bit_tick | input | 1 | One pulse per line bit time |
| full_mask | input | NPORT | Full-interrupt mask, 1 suppresses |
| nfull_mask | input | NPORT | Near-full interrupt mask, 1 suppresses |
| full_stat_rd | input | 1 | Read strobe that clears full status |
| nfull_stat_rd | input | 1 | Read strobe that clears near-full status |
| pause_ready | input | 1 | Consumer accepts the presented request |
| pause_valid | output | 1 | A pause request is presented |
| pause_port | output | IDX_W | Port index of the presented request |
| full_stat | output | NPORT | Sticky full status |
| nfull_stat | output | NPORT | Sticky near-full status |
| irq | output | 1 | Interrupt, OR of unmasked status bits |

## Verification
The hardest situation to reach is a regeneration request arriving while the consumer is stalled, with a pause episode ending near the point where a countdown would expire. The request timing follows the bit tick over hundreds of cycles. The bench therefore holds `bit_tick` high, so that each interval is an exact cycle count. It schedules level changes at absolute cycle numbers, between expiries and clear of them. Stalls come from holding `pause_ready` low across a first request. Episodes are ended, and ports disabled, between two expected expiries, and the bench then waits past the next expiry to show that nothing is emitted.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic {
      PS_IDLE  = 1'b0,
      PS_PAUSE = 1'b1
   } pause_st_e;

   function automatic int unsigned pfc_log2(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((32'd1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/pfc_port.sv
module pfc_port
   import pfc_pkg::*;
#(
   parameter int LVL_W = 12,
   parameter int TMR_W = 16,
   parameter int QLOG  = 9,
   localparam int CNT_W = TMR_W + QLOG
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [LVL_W-1:0] lvl,
   input  logic             full,
   input  logic [LVL_W-1:0] hi,
   input  logic [LVL_W-1:0] lo,
   input  logic [TMR_W-1:0] regen,
   input  logic             bit_tick,
   input  logic             grant,
   input  logic             full_rd,
   input  logic             nf_rd,
   output logic             pend,
   output logic             full_st,
   output logic             nf_st
);

   pause_st_e        st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;
   logic [TMR_W-1:0] regen_eff;
   logic             above_hi, at_lo;
   logic             enter, stay, expire;
   logic             nf_cond, full_cond;
   logic             nf_prev, full_prev;

   assign above_hi  = lvl > hi;
   assign at_lo     = lvl <= lo;
   assign regen_eff = (regen == '0) ? TMR_W'(1) : regen;
   assign reload    = {regen_eff, {QLOG{1'b0}}};

   always_comb begin
      st_d = st_q;
      if (!en)                             st_d = PS_IDLE;
      else if (st_q == PS_IDLE && above_hi) st_d = PS_PAUSE;
      else if (st_q == PS_PAUSE && at_lo)   st_d = PS_IDLE;
   end

   assign enter  = (st_q == PS_IDLE)  && (st_d == PS_PAUSE);
   assign stay   = (st_q == PS_PAUSE) && (st_d == PS_PAUSE);
   assign expire = stay && bit_tick && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= PS_IDLE;
         cnt_q <= '0;
         pend  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (enter)              cnt_q <= reload;
         else if (expire)        cnt_q <= reload;
         else if (stay && bit_tick) cnt_q <= cnt_q - CNT_W'(1);
         else if (!stay)         cnt_q <= '0;

         if (st_d == PS_IDLE)       pend <= 1'b0;
         else if (enter || expire)  pend <= 1'b1;
         else if (grant)            pend <= 1'b0;
      end
   end

   assign nf_cond   = en && above_hi;
   assign full_cond = en && full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nf_prev   <= 1'b0;
         full_prev <= 1'b0;
         nf_st     <= 1'b0;
         full_st   <= 1'b0;
      end else begin
         nf_prev   <= nf_cond;
         full_prev <= full_cond;
         nf_st     <= (nf_st & ~nf_rd) | (nf_cond & ~nf_prev);
         full_st   <= (full_st & ~full_rd) | (full_cond & ~full_prev);
      end
   end

endmodule

// File: rtl/pfc_req_arb.sv
module pfc_req_arb #(
   parameter int NPORT       = 8,
   parameter int IDX_W       = 3,
   parameter bit ROUND_ROBIN = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPORT-1:0] pend,
   input  logic             ready,
   output logic [NPORT-1:0] grant,
   output logic             valid,
   output logic [IDX_W-1:0] port
);

   logic             any;
   logic [IDX_W-1:0] sel;
   logic             load;

   generate
      if (ROUND_ROBIN) begin : g_rr
         logic [IDX_W-1:0] ptr_q;
         always_comb begin
            any = 1'b0;
            sel = '0;
            for (int k = NPORT; k >= 1; k--) begin
               int j;
               j = (int'(ptr_q) + k) % NPORT;
               if (pend[j]) begin
                  any = 1'b1;
                  sel = IDX_W'(j);
               end
            end
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    ptr_q <= IDX_W'(NPORT - 1);
            else if (load) ptr_q <= sel;
         end
      end else begin : g_fixed
         always_comb begin
            any = 1'b0;
            sel = '0;
            for (int i = NPORT - 1; i >= 0; i--) begin
               if (pend[i]) begin
                  any = 1'b1;
                  sel = IDX_W'(i);
               end
            end
         end
      end
   endgenerate

   assign load = any && (!valid || ready);

   always_comb begin
      for (int i = 0; i < NPORT; i++) grant[i] = load && (sel == IDX_W'(i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= 1'b0;
         port  <= '0;
      end else if (load) begin
         valid <= 1'b1;
         port  <= sel;
      end else if (ready) begin
         valid <= 1'b0;
      end
   end

endmodule

// File: rtl/pause_flow_ctrl.sv
module pause_flow_ctrl
   import pfc_pkg::*;
#(
   parameter int NPORT        = 8,
   parameter int LVL_W        = 12,
   parameter int TMR_W        = 16,
   parameter int QUANTUM_BITS = 512,
   parameter bit ROUND_ROBIN  = 1'b0,
   localparam int IDX_W = (NPORT > 1) ? $clog2(NPORT) : 1,
   localparam int QLOG  = $clog2(QUANTUM_BITS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NPORT-1:0]       port_en,
   input  logic [NPORT*LVL_W-1:0] fill_lvl,
   input  logic [NPORT-1:0]       fifo_full,
   input  logic [NPORT*LVL_W-1:0] hi_thr,
   input  logic [NPORT*LVL_W-1:0] lo_thr,
   input  logic [TMR_W-1:0]       regen_time,
   input  logic                   bit_tick,
   input  logic [NPORT-1:0]       full_mask,
   input  logic [NPORT-1:0]       nfull_mask,
   input  logic                   full_stat_rd,
   input  logic                   nfull_stat_rd,
   input  logic                   pause_ready,
   output logic                   pause_valid,
   output logic [IDX_W-1:0]       pause_port,
   output logic [NPORT-1:0]       full_stat,
   output logic [NPORT-1:0]       nfull_stat,
   output logic                   irq
);

   generate
      if (NPORT < 1 || NPORT > 32) begin : g_bad_nport
         $error("pause_flow_ctrl: NPORT must be 1..32");
      end
      if (QUANTUM_BITS < 2 || (1 << QLOG) != QUANTUM_BITS) begin : g_bad_quantum
         $error("pause_flow_ctrl: QUANTUM_BITS must be a power of two >= 2");
      end
      if (LVL_W < 1 || TMR_W < 1) begin : g_bad_width
         $error("pause_flow_ctrl: LVL_W and TMR_W must be positive");
      end
   endgenerate

   logic [NPORT-1:0] pend;
   logic [NPORT-1:0] grant;

   generate
      for (genvar p = 0; p < NPORT; p++) begin : g_port
         pfc_port #(
            .LVL_W (LVL_W),
            .TMR_W (TMR_W),
            .QLOG  (QLOG)
         ) u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (port_en[p]),
            .lvl      (fill_lvl[p*LVL_W +: LVL_W]),
            .full     (fifo_full[p]),
            .hi       (hi_thr[p*LVL_W +: LVL_W]),
            .lo       (lo_thr[p*LVL_W +: LVL_W]),
            .regen    (regen_time),
            .bit_tick (bit_tick),
            .grant    (grant[p]),
            .full_rd  (full_stat_rd),
            .nf_rd    (nfull_stat_rd),
            .pend     (pend[p]),
            .full_st  (full_stat[p]),
            .nf_st    (nfull_stat[p])
         );
      end
   endgenerate

   pfc_req_arb #(
      .NPORT       (NPORT),
      .IDX_W       (IDX_W),
      .ROUND_ROBIN (ROUND_ROBIN)
   ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .ready (pause_ready),
      .grant (grant),
      .valid (pause_valid),
      .port  (pause_port)
   );

   assign irq = |((full_stat & ~full_mask) | (nfull_stat & ~nfull_mask));

endmodule

// File: rtl/pfc_chk.sv
module pfc_chk #(
   parameter int NPORT = 8,
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPORT-1:0] port_en,
   input logic [NPORT-1:0] full_mask,
   input logic [NPORT-1:0] nfull_mask,
   input logic             full_stat_rd,
   input logic             nfull_stat_rd,
   input logic             pause_ready,
   input logic             pause_valid,
   input logic [IDX_W-1:0] pause_port,
   input logic [NPORT-1:0] full_stat,
   input logic [NPORT-1:0] nfull_stat,
   input logic             irq
);

   // R4
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_valid && !pause_ready) |=> (pause_valid && $stable(pause_port)));

   // R6
   full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !full_stat_rd |=> ((full_stat & $past(full_stat)) == $past(full_stat)));

   // R6
   nfull_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !nfull_stat_rd |=> ((nfull_stat & $past(nfull_stat)) == $past(nfull_stat)));

   // R7
   irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((&full_mask) && (&nfull_mask)) |-> !irq);

   // R8
   disabled_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (((full_stat | nfull_stat) & ~$past(full_stat | nfull_stat) & ~$past(port_en)) == '0));

endmodule

bind pause_flow_ctrl pfc_chk #(
   .NPORT (NPORT),
   .IDX_W (IDX_W)
) u_pfc_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .port_en       (port_en),
   .full_mask     (full_mask),
   .nfull_mask    (nfull_mask),
   .full_stat_rd  (full_stat_rd),
   .nfull_stat_rd (nfull_stat_rd),
   .pause_ready   (pause_ready),
   .pause_valid   (pause_valid),
   .pause_port    (pause_port),
   .full_stat     (full_stat),
   .nfull_stat    (nfull_stat),
   .irq           (irq)
);

// File: tb/sim_pause_flow_ctrl.sv
`timescale 1ns/1ps
module sim_pause_flow_ctrl;
   localparam int NP    = 4;
   localparam int LW    = 8;
   localparam int TW    = 16;
   localparam int QB    = 512;
   localparam int IW    = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NP-1:0]   port_en = '1;
   logic [NP*LW-1:0] lvl_v = '0;
   logic [NP-1:0]   ffull = '0;
   logic [NP*LW-1:0] hi_v = '0;
   logic [NP*LW-1:0] lo_v = '0;
   logic [TW-1:0]   regen = 16'hFFFF;
   logic            tick = 1'b1;
   logic [NP-1:0]   fmask = '1;
   logic [NP-1:0]   nmask = '1;
   logic            frd = 1'b0;
   logic            nrd = 1'b0;
   logic            rdy = 1'b1;
   logic            pv;
   logic [IW-1:0]   pp;
   logic [NP-1:0]   fst;
   logic [NP-1:0]   nst;
   logic            irq;

   int cyc = 0;
   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   int exp_port[$];
   int exp_cyc[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   pause_flow_ctrl #(.NPORT(NP), .LVL_W(LW), .TMR_W(TW), .QUANTUM_BITS(QB)) u0 (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .fill_lvl(lvl_v),
      .fifo_full(ffull), .hi_thr(hi_v), .lo_thr(lo_v), .regen_time(regen),
      .bit_tick(tick), .full_mask(fmask), .nfull_mask(nmask),
      .full_stat_rd(frd), .nfull_stat_rd(nrd), .pause_ready(rdy),
      .pause_valid(pv), .pause_port(pp), .full_stat(fst), .nfull_stat(nst),
      .irq(irq));

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, expv, cyc);
      end
   endtask

   task automatic expect_req(input int p, input int c);
      exp_port.push_back(p);
      exp_cyc.push_back(c);
   endtask

   task automatic set_lvl(input int p, input int v);
      lvl_v[p*LW +: LW] = LW'(v);
   endtask

   task automatic set_thr(input int p, input int h, input int l);
      hi_v[p*LW +: LW] = LW'(h);
      lo_v[p*LW +: LW] = LW'(l);
   endtask

   task automatic wait_cyc(input int c);
      while (cyc < c) @(negedge clk);
   endtask

   // scoreboard monitor: accepted requests against the expected queue
   always @(negedge clk) begin
      #2;
      if (rst_n && pv && rdy) begin
         if (exp_port.size() == 0) begin
            chk(1'b0, "R2/R8 unexpected request port", int'(pp), -1);
         end else begin
            int ep, ec;
            ep = exp_port.pop_front();
            ec = exp_cyc.pop_front();
            chk(int'(pp) == ep, "R4 request port", int'(pp), ep);
            chk(cyc == ec, "R3 request cycle", cyc, ec);
         end
      end
   end

   initial begin
      #(5.0 * 50000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int k;
      for (int p = 0; p < NP; p++) set_thr(p, 100, 50);
      regen = 16'd1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      // R9 reset state
      chk(pv == 1'b0, "R9 valid after reset", int'(pv), 0);
      chk(fst == '0 && nst == '0, "R9 status after reset", int'({fst, nst}), 0);
      chk(irq == 1'b0, "R9 irq after reset", int'(irq), 0);

      // R1 equal to high threshold: no entry, no near-full
      set_lvl(1, 100);
      repeat (3) @(negedge clk);
      #1;
      chk(nst == '0, "R1 level equal high, near-full", int'(nst), 0);

      // R1 R3 entry and periodic regeneration
      k = cyc;
      set_lvl(1, 101);
      expect_req(1, k + 2);
      expect_req(1, k + 2 + QB);
      expect_req(1, k + 2 + 2 * QB);
      expect_req(1, k + 2 + 3 * QB);
      @(negedge clk);
      #1;
      chk(nst == 4'b0010, "R5 near-full set on crossing", int'(nst), 2);
      // R2 hysteresis: level above low keeps pausing
      wait_cyc(k + 1200);
      set_lvl(1, 60);
      // R2 exit at low threshold, next expiry at k+2+4*QB cancelled
      wait_cyc(k + 1700);
      set_lvl(1, 50);
      wait_cyc(k + 2300);
      chk(exp_port.size() == 0, "R2 all expected requests seen", exp_port.size(), 0);

      // R8 disabling a paused port stops its requests
      k = cyc;
      set_lvl(1, 101);
      expect_req(1, k + 2);
      wait_cyc(k + 100);
      port_en[1] = 1'b0;
      wait_cyc(k + 700);
      set_lvl(1, 0);
      chk(exp_port.size() == 0, "R8 disabled port silent", exp_port.size(), 0);
      @(negedge clk);
      port_en[1] = 1'b1;

      // R8 disabled port: no status, no request
      port_en[3] = 1'b0;
      ffull[3] = 1'b1;
      set_lvl(3, 200);
      repeat (5) @(negedge clk);
      #1;
      chk(fst[3] == 1'b0 && nst[3] == 1'b0, "R8 disabled port status", int'({fst[3], nst[3]}), 0);
      ffull[3] = 1'b0;
      set_lvl(3, 0);
      @(negedge clk);
      port_en[3] = 1'b1;

      // R4 stall: request held until ready
      rdy = 1'b0;
      k = cyc;
      set_lvl(2, 150);
      wait_cyc(k + 30);
      #1;
      chk(pv == 1'b1, "R4 valid held while stalled", int'(pv), 1);
      chk(int'(pp) == 2, "R4 port held while stalled", int'(pp), 2);
      expect_req(2, k + 30);
      expect_req(2, k + 2 + QB);
      rdy = 1'b1;
      wait_cyc(k + 2 + QB + 10);
      set_lvl(2, 0);
      @(negedge clk);

      // R4 simultaneous entry: lowest index first
      k = cyc;
      set_lvl(0, 120);
      set_lvl(3, 120);
      expect_req(0, k + 2);
      expect_req(3, k + 3);
      wait_cyc(k + 20);
      set_lvl(0, 0);
      set_lvl(3, 0);
      wait_cyc(k + 30);
      chk(exp_port.size() == 0, "R4 both ports served", exp_port.size(), 0);

      // R6 clear all status
      frd = 1'b1;
      nrd = 1'b1;
      @(negedge clk);
      frd = 1'b0;
      nrd = 1'b0;
      #1;
      chk(fst == '0 && nst == '0, "R6 read clears status", int'({fst, nst}), 0);

      // R5 R7 full status and masking
      ffull[0] = 1'b1;
      @(negedge clk);
      #1;
      chk(fst == 4'b0001, "R5 full set on rising", int'(fst), 1);
      chk(irq == 1'b0, "R7 masked irq", int'(irq), 0);
      fmask = 4'b1110;
      #1;
      chk(irq == 1'b1, "R7 unmasked irq", int'(irq), 1);
      frd = 1'b1;
      @(negedge clk);
      frd = 1'b0;
      #1;
      chk(fst == '0, "R6 clear while condition held", int'(fst), 0);
      chk(irq == 1'b0, "R7 irq drops after clear", int'(irq), 0);
      ffull[0] = 1'b0;
      @(negedge clk);
      ffull[0] = 1'b1;
      frd = 1'b1;
      @(negedge clk);
      frd = 1'b0;
      #1;
      chk(fst[0] == 1'b1, "R6 set wins over read", int'(fst[0]), 1);
      ffull[0] = 1'b0;
      repeat (3) @(negedge clk);
      #1;
      chk(fst[0] == 1'b1, "R5 full status sticky", int'(fst[0]), 1);

      // R5 R7 near-full path
      fmask = '1;
      k = cyc;
      set_lvl(2, 101);
      expect_req(2, k + 2);
      @(negedge clk);
      #1;
      chk(nst == 4'b0100, "R5 near-full port 2", int'(nst), 4);
      chk(irq == 1'b0, "R7 all masked", int'(irq), 0);
      nmask = 4'b1011;
      #1;
      chk(irq == 1'b1, "R7 near-full unmasked", int'(irq), 1);
      set_lvl(2, 0);
      repeat (5) @(negedge clk);
      chk(exp_port.size() == 0, "R3 final queue empty", exp_port.size(), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule